// File: doc/BRIEF.md
# Programmable Priority Interrupt Controller

This block gathers eight active-high interrupt request lines into one interrupt output for a processor. Each line can be masked on its own. The block latches a request when its line rises. Among the pending, unmasked requests, line 0 has the highest priority and line 7 the lowest. The output is raised only when a pending request outranks every level that is already in service. The processor answers with two acknowledge pulses. The first pulse moves the winning request from the request register into the in-service register. During the second pulse the block drives an 8-bit vector onto its read data bus.

Software programs the block through a small strobe interface: an active-low chip select, active-low read and write strobes, one address bit, an 8-bit write bus and an 8-bit read bus. Setup is a two-word sequence. The first word arms the controller and picks the end-of-interrupt style. The second word gives the vector base. After setup, further words load the mask, choose what a read returns, and retire in-service levels. All logic runs on one clock. The request lines and the acknowledge input pass through two-flop synchronizers. A write takes effect once per strobe, in the first clock cycle in which the chip select and write strobe are both low.

There are two state machines. The setup machine moves through WAIT_ICW1 → WAIT_BASE → READY. A first-word write, in any state, jumps it to WAIT_BASE. The acknowledge machine moves through IDLE → FIRST on the rise of the synchronized acknowledge (in-service is taken here), then FIRST → GAP on its fall, then GAP → SECOND on the next rise (the vector is driven here), then SECOND → IDLE on the last fall (automatic end-of-interrupt happens here).

Top module: `irq_ctrl`

## Requirements
- R1: After reset, irq_out is 0, rdata is 0 and the controller waits for its first setup word. Requests are not latched until setup completes.
- R2: In READY, a rising edge on request line i sets request bit i only if mask bit i is 0. A masked line sets nothing, and masking one line does not stop lines of lower priority from latching.
- R3: On the first acknowledge pulse, the lowest-numbered pending unmasked request is cleared from the request register and its bit is set in the in-service register. No more than one in-service bit is set per pulse.
- R4: irq_out is 1 exactly when the controller is READY and the lowest-numbered pending unmasked request has a lower number than every set in-service bit (or no in-service bit is set).
- R5: While the second acknowledge pulse is seen, rdata equals {base[7:3], selected line number[2:0]}.
- R6: A write with a0=0 and data bit 4 set is the first setup word. Its bit 1 set selects automatic end-of-interrupt. It clears the request, in-service and mask registers and selects request-register reads. The next write with a0=1 stores the vector base and enters READY. Before that, irq_out stays 0 and the request register stays 0.
- R7: With chip select and read strobe low, a0=1 reads the mask, and a0=0 reads the request or the in-service register. A READY write with a0=0, bit 4 clear and bit 3 set selects the source: bit 0 = 1 picks in-service, 0 picks request. With no read and no vector phase, rdata is 0.
- R8: A READY write with a0=0, bits 4 and 3 clear and bit 5 set clears the lowest-numbered set in-service bit only.
- R9: In automatic end-of-interrupt mode, the in-service bit taken on the first pulse is cleared when the second pulse ends.
- R10: In READY, a write with a0=1 loads the mask register. A write while chip select is high has no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| wr_n | input | 1 | Write strobe, active low |
| a0 | input | 1 | Register address bit |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data or acknowledge vector |
| irq_req | input | 8 | Interrupt request lines, active high, line 0 highest |
| ack | input | 1 | Acknowledge pulses from the processor, active high |
| irq_out | output | 1 | Interrupt output to the processor |

## Verification
The bench sweeps all 256 request patterns, each paired with a different mask. For every pattern it checks the latched request register, the interrupt output and the vector winner.
- A resolver that favoured high line numbers, or let a masked line block lower ones, would return the wrong vector.
- Directed nesting cases check that a lower-priority request stays silent behind an in-service level, while a higher one breaks through.
- A design that cleared the wrong in-service bit on an end-of-interrupt command would fail these cases.
- A design that compared against the wrong level would also fail them.
- Separate cases cover automatic end-of-interrupt, writes without chip select, and requests raised before setup ends. A design that latched too early or retired too late would show a stale bit on readback.

// File: rtl/irq_pkg.sv
package irq_pkg;
    typedef enum logic [1:0] {
        CFG_WAIT_ICW1,
        CFG_WAIT_BASE,
        CFG_READY
    } cfg_state_t;

    typedef enum logic [1:0] {
        ACK_IDLE,
        ACK_FIRST,
        ACK_GAP,
        ACK_SECOND
    } ack_state_t;
endpackage

// File: rtl/irq_sync.sv
module irq_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/irq_prio.sv
module irq_prio #(
    parameter int N  = 8,
    parameter int IW = $clog2(N)
) (
    input  logic [N-1:0]  vec,
    output logic          any,
    output logic [IW-1:0] idx
);
    always_comb begin
        any = 1'b0;
        idx = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (vec[i]) begin
                any = 1'b1;
                idx = IW'(i);
            end
        end
    end
endmodule

// File: rtl/irq_ackfsm.sv
module irq_ackfsm
    import irq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ack_s,
    output ack_state_t state,
    output logic       take,
    output logic       done,
    output logic       vec_on
);
    ack_state_t state_n;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ACK_IDLE;
        else        state <= state_n;
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ACK_IDLE:   if (ack_s)  state_n = ACK_FIRST;
            ACK_FIRST:  if (!ack_s) state_n = ACK_GAP;
            ACK_GAP:    if (ack_s)  state_n = ACK_SECOND;
            ACK_SECOND: if (!ack_s) state_n = ACK_IDLE;
            default:                state_n = ACK_IDLE;
        endcase
    end

    always_comb begin
        take   = (state == ACK_IDLE) && ack_s;
        done   = (state == ACK_SECOND) && !ack_s;
        vec_on = (state == ACK_SECOND);
    end
endmodule

// File: rtl/irq_ctrl.sv
module irq_ctrl
    import irq_pkg::*;
#(
    parameter int LINES = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cs_n,
    input  logic             rd_n,
    input  logic             wr_n,
    input  logic             a0,
    input  logic [LINES-1:0] wdata,
    output logic [LINES-1:0] rdata,
    input  logic [LINES-1:0] irq_req,
    input  logic             ack,
    output logic             irq_out
);
    localparam int IW = $clog2(LINES);
    localparam int BW = LINES - IW;

    cfg_state_t       cfg_q, cfg_n;
    ack_state_t       ack_st;
    logic [LINES-1:0] req_s, req_prev, req_rise;
    logic             ack_s, take, done, vec_phase;
    logic [LINES-1:0] irr, isr, imr, irr_n, isr_n;
    logic [BW-1:0]    base;
    logic             aeoi, rd_isr, sel_valid, wr_q;
    logic [IW-1:0]    sel_line;
    logic             wr_act, wr_go, rd_act, cfg_ready;
    logic             icw1_wr, base_wr, mask_wr, cmd_wr, rdsel_wr, eoi_wr;
    logic             p_any, s_any;
    logic [IW-1:0]    p_idx, s_idx;
    logic [LINES-1:0] pend;

    irq_sync #(.W(LINES)) u_req_sync (.clk(clk), .rst_n(rst_n), .d(irq_req), .q(req_s));
    irq_sync #(.W(1))     u_ack_sync (.clk(clk), .rst_n(rst_n), .d(ack),     .q(ack_s));

    irq_ackfsm u_ackfsm (
        .clk(clk), .rst_n(rst_n), .ack_s(ack_s), .state(ack_st),
        .take(take), .done(done), .vec_on(vec_phase)
    );

    assign pend = irr & ~imr;
    irq_prio #(.N(LINES), .IW(IW)) u_prio_pend (.vec(pend), .any(p_any), .idx(p_idx));
    irq_prio #(.N(LINES), .IW(IW)) u_prio_isr  (.vec(isr),  .any(s_any), .idx(s_idx));

    // host strobe decode: one action per write strobe
    assign wr_act    = !cs_n && !wr_n;
    assign rd_act    = !cs_n && !rd_n;
    assign wr_go     = wr_act && !wr_q;
    assign cfg_ready = (cfg_q == CFG_READY);
    assign icw1_wr   = wr_go && !a0 && wdata[4];
    assign base_wr   = wr_go && a0 && (cfg_q == CFG_WAIT_BASE);
    assign mask_wr   = wr_go && a0 && cfg_ready;
    assign cmd_wr    = wr_go && !a0 && !wdata[4] && cfg_ready;
    assign rdsel_wr  = cmd_wr && wdata[3];
    assign eoi_wr    = cmd_wr && !wdata[3] && wdata[5];
    assign req_rise  = req_s & ~req_prev;

    // setup state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) cfg_q <= CFG_WAIT_ICW1;
        else        cfg_q <= cfg_n;
    end

    always_comb begin
        cfg_n = cfg_q;
        unique case (cfg_q)
            CFG_WAIT_ICW1: if (icw1_wr) cfg_n = CFG_WAIT_BASE;
            CFG_WAIT_BASE: if (base_wr) cfg_n = CFG_READY;
            CFG_READY:     if (icw1_wr) cfg_n = CFG_WAIT_BASE;
            default:                    cfg_n = CFG_WAIT_ICW1;
        endcase
    end

    // next request / in-service values
    always_comb begin
        irr_n = irr;
        isr_n = isr;
        if (take && p_any) begin
            irr_n[p_idx] = 1'b0;
            isr_n[p_idx] = 1'b1;
        end
        if (done && aeoi && sel_valid) isr_n[sel_line] = 1'b0;
        if (eoi_wr && s_any)           isr_n[s_idx]    = 1'b0;
        if (cfg_ready)                 irr_n = irr_n | (req_rise & ~imr);
        if (icw1_wr) begin
            irr_n = '0;
            isr_n = '0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wr_q      <= 1'b0;
            req_prev  <= '0;
            irr       <= '0;
            isr       <= '0;
            imr       <= '0;
            base      <= '0;
            aeoi      <= 1'b0;
            rd_isr    <= 1'b0;
            sel_line  <= '0;
            sel_valid <= 1'b0;
        end else begin
            wr_q     <= wr_act;
            req_prev <= req_s;
            irr      <= irr_n;
            isr      <= isr_n;
            if (icw1_wr) begin
                imr    <= '0;
                aeoi   <= wdata[1];
                rd_isr <= 1'b0;
            end
            if (base_wr)  base   <= wdata[LINES-1:IW];
            if (mask_wr)  imr    <= wdata;
            if (rdsel_wr) rd_isr <= wdata[0];
            if (take) begin
                sel_line  <= p_any ? p_idx : IW'(LINES - 1);
                sel_valid <= p_any;
            end
        end
    end

    // output process
    always_comb begin
        irq_out = cfg_ready && p_any && (!s_any || (p_idx < s_idx));
        if (vec_phase)   rdata = {base, sel_line};
        else if (rd_act) rdata = a0 ? imr : (rd_isr ? isr : irr);
        else             rdata = '0;
    end
endmodule

// File: rtl/irq_ctrl_chk.sv
module irq_ctrl_chk #(
    parameter int LINES = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             irq_out,
    input logic [LINES-1:0] rdata,
    input logic [LINES-1:0] irr,
    input logic [LINES-1:0] imr,
    input logic [LINES-1:0] isr,
    input logic             cfg_ready,
    input logic             rd_act,
    input logic             vec_phase
);
    // R4
    irq_needs_pending_chk: assert property (@(posedge clk) disable iff (!rst_n)
        irq_out |-> ((irr & ~imr) != '0));

    // R3
    isr_single_take_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $countones(isr & ~$past(isr)) <= 1);

    // R2
    masked_no_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((irr & ~$past(irr) & $past(imr)) == '0));

    // R6
    setup_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !cfg_ready |-> (!irq_out && (irr == '0)));

    // R7
    idle_bus_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!rd_act && !vec_phase) |-> (rdata == '0));
endmodule

bind irq_ctrl irq_ctrl_chk #(.LINES(LINES)) u_chk (.*);

// File: tb/irq_ctrl_bench.sv
module irq_ctrl_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs_n = 1'b1, rd_n = 1'b1, wr_n = 1'b1, a0 = 1'b0;
    logic [7:0] wdata = '0;
    logic [7:0] rdata;
    logic [7:0] irq_req = '0;
    logic       ack = 1'b0;
    logic       irq_out;

    int total = 0;
    int bad = 0;
    logic [7:0] vec_seen;
    logic [7:0] rd_val;

    always #10 clk = ~clk;

    irq_ctrl u_irq_ctrl (
        .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .rd_n(rd_n), .wr_n(wr_n),
        .a0(a0), .wdata(wdata), .rdata(rdata), .irq_req(irq_req),
        .ack(ack), .irq_out(irq_out)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
        end
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic adr, input logic [7:0] d);
        @(negedge clk);
        cs_n = 1'b0; wr_n = 1'b0; a0 = adr; wdata = d;
        idle(2);
        cs_n = 1'b1; wr_n = 1'b1;
        @(negedge clk);
    endtask

    task automatic rd(input logic adr);
        @(negedge clk);
        cs_n = 1'b0; rd_n = 1'b0; a0 = adr;
        #2 rd_val = rdata;
        @(negedge clk);
        cs_n = 1'b1; rd_n = 1'b1;
    endtask

    task automatic ack_seq();
        @(negedge clk);
        ack = 1'b1; idle(6);
        ack = 1'b0; idle(6);
        ack = 1'b1; idle(5);
        vec_seen = rdata;
        @(negedge clk);
        ack = 1'b0; idle(6);
    endtask

    task automatic setup(input logic [7:0] w1, input logic [7:0] vbase);
        wr(1'b0, w1);
        wr(1'b1, vbase);
    endtask

    task automatic pulse_lines(input logic [7:0] l);
        @(negedge clk);
        irq_req = l; idle(6);
        irq_req = '0; idle(4);
    endtask

    function automatic logic [2:0] lowest(input logic [7:0] v);
        logic [2:0] r = 3'd0;
        for (int i = 7; i >= 0; i--) if (v[i]) r = 3'(i);
        return r;
    endfunction

    initial begin
        idle(3);
        rst_n = 1'b1;
        idle(2);
        // R1 reset state
        check("R1 irq_out", {7'd0, irq_out}, 8'h00);
        check("R1 rdata", rdata, 8'h00);
        // R1 / R6 requests before setup are not latched
        pulse_lines(8'h01);
        check("R6 irq before setup", {7'd0, irq_out}, 8'h00);
        setup(8'h10, 8'h40);
        rd(1'b0);
        check("R6 irr after setup", rd_val, 8'h00);
        // R10 write without chip select ignored
        @(negedge clk);
        a0 = 1'b1; wdata = 8'hFF; wr_n = 1'b0; idle(2); wr_n = 1'b1;
        rd(1'b1);
        check("R10 mask no cs", rd_val, 8'h00);
        wr(1'b1, 8'h81);
        rd(1'b1);
        check("R10 mask load", rd_val, 8'h81);
        wr(1'b1, 8'h00);

        // nesting and end-of-interrupt
        pulse_lines(8'h10);
        check("R4 irq line4", {7'd0, irq_out}, 8'h01);
        ack_seq();
        check("R5 vector line4", vec_seen, 8'h44);
        pulse_lines(8'h40);
        check("R4 lower blocked", {7'd0, irq_out}, 8'h00);
        rd(1'b0);
        check("R2 irr line6", rd_val, 8'h40);
        pulse_lines(8'h04);
        check("R4 higher breaks in", {7'd0, irq_out}, 8'h01);
        ack_seq();
        check("R5 vector line2", vec_seen, 8'h42);
        wr(1'b0, 8'h09);
        rd(1'b0);
        check("R3 isr nested", rd_val, 8'h14);
        wr(1'b0, 8'h20);
        rd(1'b0);
        check("R8 eoi lowest", rd_val, 8'h10);
        check("R4 still blocked", {7'd0, irq_out}, 8'h00);
        wr(1'b0, 8'h20);
        rd(1'b0);
        check("R8 eoi second", rd_val, 8'h00);
        check("R4 released", {7'd0, irq_out}, 8'h01);

        // R9 automatic end-of-interrupt
        setup(8'h12, 8'h80);
        pulse_lines(8'h20);
        ack_seq();
        check("R9 vector line5", vec_seen, 8'h85);
        wr(1'b0, 8'h09);
        rd(1'b0);
        check("R9 isr auto clear", rd_val, 8'h00);
        check("R7 idle bus", rdata, 8'h00);

        // sweep every request pattern against a derived mask
        for (int p = 0; p < 256; p++) begin
            logic [7:0] pat = 8'(p);
            logic [7:0] msk = 8'((p * 5 + 3) & 8'hFF);
            logic [7:0] exp = pat & ~msk;
            setup(8'h10, 8'hA8);
            wr(1'b1, msk);
            pulse_lines(pat);
            rd(1'b0);
            check("R2 sweep irr", rd_val, exp);
            check("R4 sweep irq", {7'd0, irq_out}, {7'd0, exp != 8'h00});
            if (exp != 8'h00) begin
                ack_seq();
                check("R5 sweep vector", vec_seen, {5'b10101, lowest(exp)});
                wr(1'b0, 8'h09);
                rd(1'b0);
                check("R3 sweep isr", rd_val, 8'h01 << lowest(exp));
                wr(1'b0, 8'h08);
                rd(1'b0);
                check("R3 sweep irr left", rd_val, exp & ~(8'h01 << lowest(exp)));
            end
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        total++;
        bad++;
        $display("FAIL watchdog actual=timeout expected=finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule